// File: doc/BRIEF.md
# Processor Status Word with Mode and Interrupt-Enable Stacks

This block holds the 32-bit processor status word of a small RISC core. It keeps a three-level history of the privilege mode and a three-level history of the global interrupt enable. It also holds a 5-bit priority field and a 16-bit interrupt mask. Software reads the word at all times. Software writes it through the special-register port, and a write lands only when the special index selects this register, which is index 0.

Taking an exception pushes both histories: each flag moves one level deeper, and the block enters kernel mode with interrupts disabled. Returning from an exception pops both histories. The block also watches 16 pending interrupt lines. It raises a request when interrupts are enabled and a pending line is unmasked, and it names the highest-numbered such line. On exception entry, the priority field records the winning line when an interrupt is being taken. Otherwise it records the exception code supplied by the core.

Top module: `psw_core`

## Requirements
- R1: After reset, `psw_value` is 0, `user_mode` is 0 and `irq_req` is 0.
- R2: A write with `wr_en`=1 and `wr_idx`=0 loads bits 26..0 of `wr_data` one cycle later. Bits 31..27 always read 0. A write with any other index leaves the word unchanged.
- R3: The layout of the word is as follows.
  - Bits 26/25/24 hold the user-mode flags: current, previous, old.
  - Bits 23/22/21 hold the interrupt-enable flags: current, previous, old.
  - Bits 20..16 hold the priority.
  - Bits 15..0 hold the mask.
  - `user_mode` equals bit 26.
- R4: On `exc_enter`, in both stacks, current moves to previous and previous moves to old, and the new current flag is 0.
- R5: On `exc_return` alone, in both stacks, previous moves to current and old moves to previous, and old keeps its value. The mask is unchanged by entry and by return, and the priority is unchanged by return.
- R6: `irq_req` is 1 exactly when the current enable (bit 23) is 1 and `irq_pending & mask` is nonzero. It is combinational from the current state.
- R7: `irq_num` is the highest index set in `irq_pending & mask` while `irq_req` is 1, and it is 0 otherwise.
- R8: On `exc_enter`, the priority field loads `irq_num` if `irq_req` is 1, and loads `exc_code` otherwise.
- R9: When events coincide in one cycle, entry beats return, and return beats a register write. The losing operations have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Special-register write strobe |
| wr_idx | input | 3 | Special-register index of the write |
| wr_data | input | 32 | Write data |
| exc_enter | input | 1 | Exception entry event |
| exc_code | input | 5 | Exception number for non-interrupt entries |
| exc_return | input | 1 | Return-from-exception event |
| irq_pending | input | 16 | Pending interrupt lines |
| psw_value | output | 32 | Current status word |
| user_mode | output | 1 | Current user-mode flag |
| irq_req | output | 1 | Interrupt may be taken |
| irq_num | output | 5 | Winning interrupt line |

## Verification
The bench drives pending patterns in which masked lines sit above unmasked ones. A priority encoder that ignored the mask, or that picked the lowest line, would name the wrong number. It pushes and then pops a stack whose old flag differs from its previous flag. A pop that shifted zero into the old slot, or a push that kept the current flag, would leave a visibly wrong word. It takes an interrupt entry with a different exception code on the port, which catches a priority field loaded from the wrong source. It also fires entry, return and a write together, which exposes a wrong precedence order.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int WORD_W    = 32;
  localparam int LINES     = 16;
  localparam int PRIO_W    = 5;
  localparam int STACK_D   = 3;
  localparam int MASK_LSB  = 0;
  localparam int PRIO_LSB  = MASK_LSB + LINES;
  localparam int IE_LSB    = PRIO_LSB + PRIO_W;
  localparam int US_LSB    = IE_LSB + STACK_D;
  localparam int USED_W    = US_LSB + STACK_D;
endpackage

// File: rtl/psw_bit_stack.sv
module psw_bit_stack #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             load,
  input  logic [DEPTH-1:0] load_val,
  output logic [DEPTH-1:0] bits
);
  // bits[DEPTH-1] is the current level, bits[0] the oldest
  logic [DEPTH-1:0] bits_d;

  always_comb begin
    bits_d = bits;
    if (push)
      bits_d = {1'b0, bits[DEPTH-1:1]};
    else if (pop)
      bits_d = {bits[DEPTH-2:0], bits[0]};
    else if (load)
      bits_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bits <= '0;
    else
      bits <= bits_d;
  end

  AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (bits[DEPTH-1] == 1'b0) && (bits[DEPTH-2:0] == $past(bits[DEPTH-1:1]))) // R4
    else $error("push shift wrong");

  AST_POP_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (bits[0] == $past(bits[0])) && (bits[DEPTH-1:1] == $past(bits[DEPTH-2:0]))) // R5
    else $error("pop shift wrong");
endmodule

// File: rtl/psw_irq_pick.sv
module psw_irq_pick #(
  parameter int LINES = 16,
  parameter int NUM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LINES-1:0] pending,
  input  logic [LINES-1:0] mask,
  output logic             req,
  output logic [NUM_W-1:0] num
);
  logic [LINES-1:0] qual;
  logic [NUM_W-1:0] top_idx;

  assign qual = pending & mask;

  // ascending scan: the last hit is the highest line
  always_comb begin
    top_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (qual[i]) top_idx = NUM_W'(i);
    end
  end

  assign req = enable && (|qual);
  assign num = req ? top_idx : '0;

  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (enable && (|(pending & mask)))) // R6
    else $error("request without enable or qualified line");

  AST_NUM_IS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (pending[num] && mask[num])) // R7
    else $error("winning line not qualified");

  AST_NUM_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (num == '0)) // R7
    else $error("number nonzero while idle");
endmodule

// File: rtl/psw_core.sv
module psw_core
  import psw_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int PSW_INDEX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              exc_enter,
  input  logic [PRIO_W-1:0] exc_code,
  input  logic              exc_return,
  input  logic [LINES-1:0]  irq_pending,
  output logic [WORD_W-1:0] psw_value,
  output logic              user_mode,
  output logic              irq_req,
  output logic [PRIO_W-1:0] irq_num
);
  logic [STACK_D-1:0] us_bits, ie_bits;
  logic [PRIO_W-1:0]  prio_q, prio_d;
  logic [LINES-1:0]   mask_q, mask_d;
  logic               wr_hit, do_pop, do_load;
  logic               unused_hi;

  assign unused_hi = ^wr_data[WORD_W-1:USED_W];
  assign wr_hit    = wr_en && (wr_idx == IDX_W'(PSW_INDEX));
  assign do_pop    = exc_return && !exc_enter;
  assign do_load   = wr_hit && !exc_enter && !exc_return;

  psw_bit_stack #(.DEPTH(STACK_D)) u_user (
    .clk(clk), .rst_n(rst_n), .push(exc_enter), .pop(do_pop), .load(do_load),
    .load_val(wr_data[US_LSB +: STACK_D]), .bits(us_bits));

  psw_bit_stack #(.DEPTH(STACK_D)) u_ien (
    .clk(clk), .rst_n(rst_n), .push(exc_enter), .pop(do_pop), .load(do_load),
    .load_val(wr_data[IE_LSB +: STACK_D]), .bits(ie_bits));

  psw_irq_pick #(.LINES(LINES), .NUM_W(PRIO_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .enable(ie_bits[STACK_D-1]),
    .pending(irq_pending), .mask(mask_q), .req(irq_req), .num(irq_num));

  always_comb begin
    prio_d = prio_q;
    mask_d = mask_q;
    if (exc_enter)
      prio_d = irq_req ? irq_num : exc_code;
    else if (do_load) begin
      prio_d = wr_data[PRIO_LSB +: PRIO_W];
      mask_d = wr_data[MASK_LSB +: LINES];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      mask_q <= '0;
    end else begin
      prio_q <= prio_d;
      mask_q <= mask_d;
    end
  end

  assign psw_value = {{(WORD_W-USED_W){1'b0}}, us_bits, ie_bits, prio_q, mask_q};
  assign user_mode = us_bits[STACK_D-1];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !exc_enter && !exc_return) |=> psw_value[USED_W-1:0] == $past(wr_data[USED_W-1:0])) // R2
    else $error("write did not land");

  AST_OTHER_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !exc_enter && !exc_return) |=> psw_value == $past(psw_value)) // R2
    else $error("word changed without cause");

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_enter || exc_return) |=> mask_q == $past(mask_q)) // R5
    else $error("mask changed on entry or return");

  AST_ENTRY_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter |=> prio_q == ($past(irq_req) ? $past(irq_num) : $past(exc_code))) // R8
    else $error("priority source wrong");

  AST_KERNEL_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter |=> (!user_mode && !irq_req)) // R4
    else $error("entry left user mode or request");
endmodule

// File: tb/psw_core_test.sv
module psw_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        exc_enter = 1'b0;
  logic [4:0]  exc_code = '0;
  logic        exc_return = 1'b0;
  logic [15:0] irq_pending = '0;
  logic [31:0] psw_value;
  logic        user_mode, irq_req;
  logic [4:0]  irq_num;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  psw_core uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .exc_enter(exc_enter), .exc_code(exc_code), .exc_return(exc_return),
    .irq_pending(irq_pending), .psw_value(psw_value), .user_mode(user_mode),
    .irq_req(irq_req), .irq_num(irq_num));

  typedef struct packed {
    logic [31:0] wv;
    logic [15:0] pend;
    logic        req;
    logic [4:0]  num;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0080_FFFF, 16'h0001, 1'b1, 5'd0},
    '{32'h0080_FFFF, 16'h8001, 1'b1, 5'd15},
    '{32'h0080_00F0, 16'h010F, 1'b0, 5'd0},
    '{32'h0000_FFFF, 16'hFFFF, 1'b0, 5'd0},
    '{32'h0080_0F00, 16'h0A10, 1'b1, 5'd11},
    '{32'h0080_0024, 16'h0027, 1'b1, 5'd5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_psw(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic en, input logic [4:0] code, input logic ret,
                       input logic we, input logic [31:0] d);
    @(negedge clk);
    exc_enter = en; exc_code = code; exc_return = ret;
    wr_en = we; wr_idx = 3'd0; wr_data = d;
    @(negedge clk);
    exc_enter = 1'b0; exc_return = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    irq_pending = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R1 value", psw_value, 32'h0);
    chk("R1 user_mode", {31'b0, user_mode}, 32'h0);
    chk("R1 irq_req", {31'b0, irq_req}, 32'h0);
    rst_n = 1'b1;
    irq_pending = '0;

    for (int i = 0; i < 6; i++) begin
      write_psw(3'd0, VECS[i].wv);
      chk("R2 readback", psw_value, VECS[i].wv);
      irq_pending = VECS[i].pend;
      #1;
      chk("R6 irq_req", {31'b0, irq_req}, {31'b0, VECS[i].req});
      chk("R7 irq_num", {27'b0, irq_num}, {27'b0, VECS[i].num});
      irq_pending = '0;
    end

    write_psw(3'd0, 32'hFFFF_FFFF);
    chk("R2 unused bits zero", psw_value, 32'h07FF_FFFF);
    chk("R3 user_mode is bit 26", {31'b0, user_mode}, 32'h1);
    write_psw(3'd1, 32'h0);
    chk("R2 other index ignored", psw_value, 32'h07FF_FFFF);

    write_psw(3'd0, 32'h05C0_0003);
    pulse(1'b1, 5'd7, 1'b0, 1'b0, 32'h0);
    chk("R4 push, R8 exc_code", psw_value, 32'h0267_0003);
    chk("R4 kernel mode", {31'b0, user_mode}, 32'h0);

    pulse(1'b0, 5'd0, 1'b1, 1'b0, 32'h0);
    chk("R5 pop keeps old", psw_value, 32'h04E7_0003);
    chk("R3 user_mode after pop", {31'b0, user_mode}, 32'h1);

    @(negedge clk);
    irq_pending = 16'h0003;
    #1;
    chk("R7 pre-entry num", {27'b0, irq_num}, 32'd1);
    pulse(1'b1, 5'd20, 1'b0, 1'b0, 32'h0);
    chk("R8 priority from line", psw_value, 32'h0261_0003);
    chk("R6 no request after entry", {31'b0, irq_req}, 32'h0);
    irq_pending = '0;

    pulse(1'b1, 5'd9, 1'b1, 1'b1, 32'hFFFF_FFFF);
    chk("R9 entry wins", psw_value, 32'h0129_0003);
    pulse(1'b0, 5'd0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    chk("R9 return beats write", psw_value, 32'h0369_0003);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule